// File: doc/BRIEF.md
# Serial-Bus and Video-Bank Port Register

This block is an 8-bit memory-mapped I/O port paired with a direction register, as used in a home-computer interface adapter. A CPU writes a data latch and a direction mask; the block combines them into a driven value, and each bit of that value has a fixed job. Bits 1:0 select which 16 KB quarter of memory the video controller reads. Bits 3, 4 and 5 control three open-collector serial-bus lines (attention, clock, data). Bit 2 is a serial transmit level.

The serial-bus lines are shared with other devices and behave as a wired-AND: a line is low whenever any device pulls it. The block only reports its own pull requests. The resolved clock and data line levels come back on two inputs, and the CPU reads them in the top two bits of the data port. Any bit whose direction bit is 0 counts as 1 in the driven value. After reset the direction register is all zeros, so all three bus lines are pulled and the video bank code is 3.

Top module: `sbus_port`

## Requirements
- R1: While reset is held, and right after it is released, the direction register reads 0x00, `bank_sel` is 3, `atn_pull`, `clk_pull` and `dat_pull` are all 1, and `txd` is 1.
- R2: A write strobe whose address has 0xDD in bits 15:8 and 0 in bits 3:0 loads the data latch. The new value appears at the outputs right after the next rising clock edge.
- R3: A write strobe whose address has 0xDD in bits 15:8 and 2 in bits 3:0 loads the direction register. A read at that address returns the register unchanged.
- R4: The driven value is the data latch ORed with the complement of the direction register, so every bit set as input (direction bit 0) acts as 1.
- R5: `bank_sel` equals bits 1:0 of the driven value. Code 3 selects memory 0x0000–0x3FFF, 2 selects 0x4000–0x7FFF, 1 selects 0x8000–0xBFFF, and 0 selects 0xC000–0xFFFF.
- R6: Driven bit 3 drives `atn_pull`, bit 4 drives `clk_pull` and bit 5 drives `dat_pull`. A 1 means the block pulls that line low and a 0 means it releases it.
- R7: A read at data offset 0 returns bit 7 = `dat_line_in` and bit 6 = `clk_line_in`, where 1 means the line is high. Bits 5:3 are the latched data bits 5:3, bit 2 is `txd`, and bits 1:0 are `bank_sel`. A line pulled low by another device reads as 0.
- R8: `txd` takes data bit 2 on the same clock edge as a register write, but only while direction bit 2 is 1. While that bit is 0, `txd` keeps its value.
- R9: Only address bits 15:8 (which must be 0xDD) and bits 3:0 are decoded, so the two registers repeat across the window. Writes at any other offset or outside the window change nothing. Reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| bank_sel | output | 2 | Video memory bank code |
| atn_pull | output | 1 | 1 = pull the attention line low |
| clk_pull | output | 1 | 1 = pull the bus clock line low |
| dat_pull | output | 1 | 1 = pull the bus data line low |
| clk_line_in | input | 1 | Resolved bus clock line level |
| dat_line_in | input | 1 | Resolved bus data line level |
| txd | output | 1 | Serial transmit level |

## Verification
The data latch and the direction register act directly on the bank code and the three pull outputs, so a corrupted bit shows at the ports right after the clock edge that stored it. A wrong `txd` hold shows up when the transmit level follows a data write while direction bit 2 is 0. A decode fault that lets a stray write through shows on the next read-back of either register. Line-sampling faults show up only when a second device pulls a line the block itself has released, so the stimulus includes that case.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int unsigned PORT_W = 8;

  // bit roles inside the driven value / read word
  localparam int unsigned BIT_TXD    = 2;
  localparam int unsigned BIT_ATN    = 3;
  localparam int unsigned BIT_CLK    = 4;
  localparam int unsigned BIT_DAT    = 5;
  localparam int unsigned BIT_CLK_IN = 6;
  localparam int unsigned BIT_DAT_IN = 7;
  localparam int unsigned BANK_W     = 2;
  localparam int unsigned NUM_LINES  = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/sbus_rst_sync.sv
module sbus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbus_decode.sv
module sbus_decode
  import sbus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_W    = 8,
  parameter int unsigned OFS_W    = 4,
  parameter logic [7:0]  WIN_BASE = 8'hDD,
  parameter logic [3:0]  DATA_OFS = 4'h0,
  parameter logic [3:0]  DIR_OFS  = 4'h2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_sel_e          sel,
  output logic              we_data,
  output logic              we_dir
);
  localparam int unsigned HI_LSB = ADDR_W - WIN_W;

  logic             in_win;
  logic [OFS_W-1:0] ofs;
  logic             unused_mid_bits;

  assign in_win          = (addr[ADDR_W-1:HI_LSB] == WIN_BASE[WIN_W-1:0]);
  assign ofs             = addr[OFS_W-1:0];
  assign unused_mid_bits = ^addr[HI_LSB-1:OFS_W];

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      if (ofs == DATA_OFS[OFS_W-1:0])     sel = SEL_DATA;
      else if (ofs == DIR_OFS[OFS_W-1:0]) sel = SEL_DIR;
    end
  end

  assign we_data = wr_en && (sel == SEL_DATA);
  assign we_dir  = wr_en && (sel == SEL_DIR);
endmodule

// File: rtl/sbus_regs.sv
module sbus_regs
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_data,
  input  logic              we_dir,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] dir_q,
  output logic              txd_q
);
  logic [PORT_W-1:0] data_d;
  logic [PORT_W-1:0] dir_d;
  logic              txd_d;
  logic              reg_en;

  always_comb begin
    data_d = we_data ? wdata : data_q;
    dir_d  = we_dir  ? wdata : dir_q;
    txd_d  = dir_d[BIT_TXD] ? data_d[BIT_TXD] : txd_q;
    reg_en = we_data || we_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      txd_q  <= 1'b1;
    end else if (reg_en) begin
      data_q <= data_d;
      dir_q  <= dir_d;
      txd_q  <= txd_d;
    end
  end

  // R2: a data write lands in the latch at the next edge
  a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_data |=> (data_q == $past(wdata)));

  // R3: a direction write lands in the register at the next edge
  a_r3_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir |=> (dir_q == $past(wdata)));

  // R8: transmit level holds while its direction bit stays input
  a_r8_txd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q[BIT_TXD] && !we_dir) |=> $stable(txd_q));
endmodule

// File: rtl/sbus_lines.sv
module sbus_lines
  import sbus_pkg::*;
(
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic              txd_q,
  input  reg_sel_e          sel,
  input  logic              clk_line_in,
  input  logic              dat_line_in,
  output logic [BANK_W-1:0] bank,
  output logic [NUM_LINES-1:0] pulls,
  output logic [PORT_W-1:0] rd_data
);
  logic [PORT_W-1:0] drive;
  logic              unused_drive_bits;

  assign drive             = data_q | ~dir_q;
  assign bank              = drive[BANK_W-1:0];
  assign unused_drive_bits = ^{drive[BIT_DAT_IN], drive[BIT_CLK_IN], drive[BIT_TXD]};

  // pulls[0]=attention, [1]=clock, [2]=data: consecutive driven bits
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pull
    assign pulls[i] = drive[BIT_ATN + i];
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_data = {dat_line_in, clk_line_in,
                           data_q[BIT_DAT:BIT_ATN], txd_q, bank};
      SEL_DIR:  rd_data = dir_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sbus_port.sv
module sbus_port
  import sbus_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [7:0]  WIN_BASE    = 8'hDD,
  parameter logic [3:0]  DATA_OFS    = 4'h0,
  parameter logic [3:0]  DIR_OFS     = 4'h2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [1:0]        bank_sel,
  output logic              atn_pull,
  output logic              clk_pull,
  output logic              dat_pull,
  input  logic              clk_line_in,
  input  logic              dat_line_in,
  output logic              txd
);
  logic              rst_sync_n;
  reg_sel_e          sel;
  logic              we_data;
  logic              we_dir;
  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] dir_q;
  logic              txd_q;
  logic [NUM_LINES-1:0] pulls;

  sbus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sbus_decode #(
    .ADDR_W(ADDR_W), .WIN_W(8), .OFS_W(4),
    .WIN_BASE(WIN_BASE), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .sel(sel), .we_data(we_data), .we_dir(we_dir)
  );

  sbus_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we_data(we_data), .we_dir(we_dir),
    .wdata(wr_data), .data_q(data_q), .dir_q(dir_q), .txd_q(txd_q)
  );

  sbus_lines u_lines (
    .data_q(data_q), .dir_q(dir_q), .txd_q(txd_q), .sel(sel),
    .clk_line_in(clk_line_in), .dat_line_in(dat_line_in),
    .bank(bank_sel), .pulls(pulls), .rd_data(rd_data)
  );

  assign atn_pull = pulls[0];
  assign clk_pull = pulls[1];
  assign dat_pull = pulls[2];
  assign txd      = txd_q;

  // R9: a strobe that decodes to no register leaves both registers alone
  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (sel == SEL_NONE)) |=> ($stable(data_q) && $stable(dir_q)));

  // R1: a freshly cleared port pulls all three lines
  a_r1_reset_pulls: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (atn_pull && clk_pull && dat_pull && (bank_sel == 2'd3)));
endmodule

// File: tb/sbus_port_tb_top.sv
module sbus_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] dat;
    logic       oc;      // other device pulls clock
    logic       od;      // other device pulls data
    logic [1:0] bank;
    logic [2:0] pulls;   // {data, clock, attention}
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 1'b0, 1'b0, 2'd3, 3'b111},
    '{8'hFF, 8'h00, 1'b0, 1'b0, 2'd0, 3'b000},
    '{8'hFF, 8'h39, 1'b0, 1'b1, 2'd1, 3'b111},
    '{8'h3F, 8'h12, 1'b0, 1'b0, 2'd2, 3'b010},
    '{8'h03, 8'h01, 1'b0, 1'b0, 2'd1, 3'b111},
    '{8'h3C, 8'h2B, 1'b1, 1'b1, 2'd3, 3'b101},
    '{8'h38, 8'h00, 1'b1, 1'b0, 2'd3, 3'b000},
    '{8'h3B, 8'h0A, 1'b0, 1'b1, 2'd2, 3'b001}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [1:0]  bank_sel;
  logic        atn_pull, clk_pull, dat_pull;
  logic        clk_line_in, dat_line_in;
  logic        txd;
  logic        oth_clk, oth_dat;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND bus: low if any device pulls
  assign clk_line_in = ~(clk_pull | oth_clk);
  assign dat_line_in = ~(dat_pull | oth_dat);

  sbus_port dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .bank_sel(bank_sel), .atn_pull(atn_pull),
    .clk_pull(clk_pull), .dat_pull(dat_pull), .clk_line_in(clk_line_in),
    .dat_line_in(dat_line_in), .txd(txd)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 16'h0000; wr_data = 8'h00;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic       txd_m;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0;
    oth_clk = 1'b0; oth_dat = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 pulls in reset", {5'b0, dat_pull, clk_pull, atn_pull}, 8'h07);
    check("R1 bank in reset", {6'b0, bank_sel}, 8'h03);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: state after release
    check("R1 bank", {6'b0, bank_sel}, 8'h03);
    check("R1 pulls", {5'b0, dat_pull, clk_pull, atn_pull}, 8'h07);
    check("R1 txd", {7'b0, txd}, 8'h01);
    bus_read(16'hDD02, rd); check("R1 dir read", rd, 8'h00);
    bus_read(16'hDD00, rd); check("R1 R7 data read", rd, 8'h07);

    // vector walk: R2 R3 R4 R5 R6 R7 R8
    txd_m = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] exp_rd;
      logic       cl, dl;
      bus_write(16'hDD02, VECS[i].dir);
      bus_write(16'hDD00, VECS[i].dat);
      oth_clk = VECS[i].oc; oth_dat = VECS[i].od;
      if (VECS[i].dir[2]) txd_m = VECS[i].dat[2];
      #1;
      check("R4 R5 bank", {6'b0, bank_sel}, {6'b0, VECS[i].bank});
      check("R4 R6 pulls", {5'b0, dat_pull, clk_pull, atn_pull}, {5'b0, VECS[i].pulls});
      check("R8 txd", {7'b0, txd}, {7'b0, txd_m});
      cl = ~(VECS[i].pulls[1] | VECS[i].oc);
      dl = ~(VECS[i].pulls[2] | VECS[i].od);
      exp_rd = {dl, cl, VECS[i].dat[5:3], txd_m, VECS[i].bank};
      bus_read(16'hDD00, rd); check("R2 R7 data read", rd, exp_rd);
      bus_read(16'hDD02, rd); check("R3 dir read", rd, VECS[i].dir);
    end
    oth_clk = 1'b0; oth_dat = 1'b0;

    // R8: direction bit 2 is 0, txd (now 0) must hold across a data write
    bus_write(16'hDD00, 8'h04);
    #1; check("R8 txd held", {7'b0, txd}, 8'h00);
    // R8: setting direction bit 2 copies latched bit 2 on that edge
    bus_write(16'hDD02, 8'h04);
    #1; check("R8 txd on dir write", {7'b0, txd}, 8'h01);

    // R9: aliases through bits 7:4
    bus_write(16'hDDF2, 8'hFF);
    bus_read(16'hDD02, rd); check("R9 alias dir", rd, 8'hFF);
    bus_write(16'hDD30, 8'h00);
    #1; check("R9 alias data bank", {6'b0, bank_sel}, 8'h00);
    // R9: stray writes change nothing
    bus_write(16'hDD01, 8'h55);
    bus_write(16'hDC02, 8'h55);
    bus_write(16'hDE00, 8'h55);
    bus_read(16'hDD02, rd); check("R9 dir untouched", rd, 8'hFF);
    #1; check("R9 bank untouched", {6'b0, bank_sel}, 8'h00);
    check("R9 pulls untouched", {5'b0, dat_pull, clk_pull, atn_pull}, 8'h00);
    bus_read(16'hDD01, rd); check("R9 unmapped read", rd, 8'h00);
    bus_read(16'hDE00, rd); check("R9 outside read", rd, 8'h00);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid reset bank", {6'b0, bank_sel}, 8'h03);
    check("R1 mid reset pulls", {5'b0, dat_pull, clk_pull, atn_pull}, 8'h07);
    check("R1 mid reset txd", {7'b0, txd}, 8'h01);
    bus_read(16'hDD02, rd); check("R1 mid reset dir", rd, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule